// File: doc/BRIEF.md
# Edge-Gated Charge Timing Controller

This block times a constant-current charge window from two external edge inputs. Each of two status channels watches one of the inputs. The input, and whether a rising or a falling transition counts, are set by software for each channel. A qualifying transition sets that channel's sticky status flag. The current-source enable is on while exactly one flag is set. A measurement therefore starts on one edge and stops on the other.

The same gating condition can drive a pulse pin. When a status evaluation ends with the flags not in the exactly-one state, a single-cycle ADC trigger can be fired. A comparator level can also set the second flag, which closes the window from an analog threshold. A discharge control grounds the measured node. While discharge is on, the current source is held off.

Software programs the block through two 8-bit control registers, selected by one address bit. Reads of the low register return the live flags, including flags set by hardware.

Top module: `chrg_gate_ctrl`

## Requirements
- R1: After synchronous reset, both registers read zero and cur_en, pulse_out, dis_out and adc_trig are low.
- R2: Source select per channel (low register bits 5:4 for channel A, 7:6 for channel B). 2'b11 routes edge_in[0]. 2'b10 routes edge_in[1]. 2'b00 and 2'b01 connect nothing. Each input passes a two-stage synchronizer, so a flag sets on the third rising clock edge after the input changes.
- R3: Polarity bit per channel (low bit 2 for A, bit 3 for B). 1 selects rising transitions and 0 selects falling ones. Flags (low bit 0 for A, bit 1 for B) are set only by hardware events. A software write to the low register loads them, which is how they are cleared.
- R4: High register bit 1 (edge enable) clear blocks edge detection. The input levels are still tracked, so setting the bit again produces no edge from a change that happened while it was clear.
- R5: cur_en is high exactly when run (high bit 0) is set, discharge is clear, and exactly one flag is set.
- R6: pulse_out is high exactly when run and pulse enable (high bit 2) are set and exactly one flag is set.
- R7: With trigger enable (high bit 3) set, adc_trig goes high for one cycle after each evaluation whose resulting flags are not exactly one set. An evaluation is a low-register write or a hardware event that sets a clear flag. High-register writes do not evaluate.
- R8: While run and pulse enable are set, a high comp_in (two-stage synchronized) sets flag B. Otherwise comp_in has no effect.
- R9: Discharge enable (high bit 4) drives dis_out high and forces cur_en low. Clearing it restores cur_en from the flags.
- R10: With run clear, edges and comp_in set no flag, no trigger fires, and cur_en, pulse_out and dis_out are low. Software writes still load both registers.
- R11: rd_sel 0 returns the high register with bits 7:5 read as zero. rd_sel 1 returns the low register with live flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 high register, 1 low register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 high register, 1 low register |
| rd_data | output | 8 | Read data |
| edge_in | input | 2 | Asynchronous edge inputs; bit 0 is input 1, bit 1 is input 2 |
| comp_in | input | 1 | Asynchronous comparator level |
| cur_en | output | 1 | Current-source enable |
| dis_out | output | 1 | Discharge-to-ground control |
| pulse_out | output | 1 | Pulse output |
| adc_trig | output | 1 | Single-cycle ADC trigger |

## Verification
Channel A starts on a rising edge of input 1 and channel B on a falling edge of input 2. This opens and then closes the window, which shows that routing and polarity are independent per channel. The opposite transitions, and the unconnected select codes, must leave the flags alone. This separates a correct polarity decode from one that reacts to any change. A transition made while edge detection is blocked, followed by re-enabling it, separates level tracking from a stale previous level. The window is also closed by the comparator, with and without pulse enable, and by software clears, with the trigger enabled and disabled.

// File: rtl/chrg_pkg.sv
package chrg_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        SRC_OFF0 = 2'b00,
        SRC_OFF1 = 2'b01,
        SRC_IN2  = 2'b10,
        SRC_IN1  = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic [2:0] rsvd;
        logic       dis_en;
        logic       trig_en;
        logic       pulse_en;
        logic       edge_en;
        logic       run;
    } hi_reg_t;

    typedef struct packed {
        src_sel_e src_b;
        src_sel_e src_a;
        logic     pol_b;
        logic     pol_a;
        logic     flag_b;
        logic     flag_a;
    } lo_reg_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic pick_edge(edge_t e, logic pol);
        return pol ? e.rise : e.fall;
    endfunction

    function automatic logic chan_hit(src_sel_e sel, logic pol, edge_t e1, edge_t e2);
        case (sel)
            SRC_IN1: return pick_edge(e1, pol);
            SRC_IN2: return pick_edge(e2, pol);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic one_set(logic a, logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/chrg_edge_det.sv
module chrg_edge_det #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    localparam int TOP = STAGES - 1;

    logic [WIDTH-1:0] prev_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst) sh_q <= '0;
            else     sh_q <= {sh_q[STAGES-2:0], din[g]};
        end
        assign lvl[g] = sh_q[TOP];
    end

    // previous level is always tracked, whatever the enables say
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    p_no_dual_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (rise & fall) == '0);

endmodule

// File: rtl/chrg_ctrl_regs.sv
module chrg_ctrl_regs
    import chrg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output hi_reg_t          hi,
    output lo_reg_t          lo_cfg,
    output logic             lo_wr,
    output logic [1:0]       lo_wr_flags
);
    hi_reg_t hi_q;
    lo_reg_t cfg_q;
    lo_reg_t wr_lo;

    assign wr_lo = lo_reg_t'(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            cfg_q <= '0;
        end else if (wr_en) begin
            if (!wr_sel) begin
                hi_q      <= hi_reg_t'(wr_data);
                hi_q.rsvd <= '0;
            end else begin
                cfg_q        <= wr_lo;
                cfg_q.flag_a <= 1'b0;
                cfg_q.flag_b <= 1'b0;
            end
        end
    end

    assign hi          = hi_q;
    assign lo_cfg      = cfg_q;
    assign lo_wr       = wr_en & wr_sel;
    assign lo_wr_flags = {wr_lo.flag_b, wr_lo.flag_a};

    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (rst)
        hi.rsvd == 3'b000);

endmodule

// File: rtl/chrg_status.sv
module chrg_status
    import chrg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  hi_reg_t    hi,
    input  lo_reg_t    lo_cfg,
    input  logic       lo_wr,
    input  logic [1:0] lo_wr_flags,
    input  edge_t      e1,
    input  edge_t      e2,
    input  logic       comp_lvl,
    output logic       flag_a,
    output logic       flag_b,
    output logic       adc_trig
);
    logic fa_q, fb_q, trig_q;
    logic edges_on, set_a, set_b, comp_set;
    logic base_a, base_b, next_a, next_b, eval;

    assign edges_on = hi.run & hi.edge_en;
    assign set_a    = edges_on & chan_hit(lo_cfg.src_a, lo_cfg.pol_a, e1, e2);
    assign comp_set = hi.run & hi.pulse_en & comp_lvl;
    assign set_b    = (edges_on & chan_hit(lo_cfg.src_b, lo_cfg.pol_b, e1, e2)) | comp_set;

    assign base_a = lo_wr ? lo_wr_flags[0] : fa_q;
    assign base_b = lo_wr ? lo_wr_flags[1] : fb_q;
    assign next_a = base_a | set_a;
    assign next_b = base_b | set_b;

    assign eval = hi.run & (lo_wr | (set_a & ~base_a) | (set_b & ~base_b));

    always_ff @(posedge clk) begin
        if (rst) begin
            fa_q   <= 1'b0;
            fb_q   <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            fa_q   <= next_a;
            fb_q   <= next_b;
            trig_q <= eval & hi.trig_en & ~one_set(next_a, next_b);
        end
    end

    assign flag_a   = fa_q;
    assign flag_b   = fb_q;
    assign adc_trig = trig_q;

    p_sticky_a_r3: assert property (@(posedge clk) disable iff (rst)
        flag_a && !lo_wr |=> flag_a);
    p_sticky_b_r3: assert property (@(posedge clk) disable iff (rst)
        flag_b && !lo_wr |=> flag_b);
    p_quiet_no_event_r4: assert property (@(posedge clk) disable iff (rst)
        !lo_wr && !set_a && !set_b |=> $stable({flag_a, flag_b}));
    p_trig_gated_r7: assert property (@(posedge clk) disable iff (rst)
        !hi.trig_en |=> !adc_trig);
    p_idle_no_trig_r10: assert property (@(posedge clk) disable iff (rst)
        !hi.run |=> !adc_trig);

endmodule

// File: rtl/chrg_drive.sv
module chrg_drive
    import chrg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  hi_reg_t hi,
    input  logic    flag_a,
    input  logic    flag_b,
    output logic    cur_en,
    output logic    pulse_out,
    output logic    dis_out
);
    logic window;

    assign window    = one_set(flag_a, flag_b);
    assign dis_out   = hi.run & hi.dis_en;
    assign cur_en    = hi.run & ~hi.dis_en & window;
    assign pulse_out = hi.run & hi.pulse_en & window;

    p_dis_blocks_cur_r9: assert property (@(posedge clk) disable iff (rst)
        dis_out |-> !cur_en);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !hi.run |-> !(cur_en || pulse_out || dis_out));
    p_cur_needs_window_r5: assert property (@(posedge clk) disable iff (rst)
        cur_en |-> (flag_a != flag_b));

endmodule

// File: rtl/chrg_gate_ctrl.sv
module chrg_gate_ctrl
    import chrg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic [1:0]       edge_in,
    input  logic             comp_in,
    output logic             cur_en,
    output logic             dis_out,
    output logic             pulse_out,
    output logic             adc_trig
);
    localparam int N_IN = 3;

    hi_reg_t    hi;
    lo_reg_t    lo_cfg, lo_live;
    logic       lo_wr;
    logic [1:0] lo_wr_flags;
    logic [N_IN-1:0] lvl, rise, fall;
    edge_t      e1, e2;
    logic       flag_a, flag_b;

    chrg_edge_det #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_det (
        .clk  (clk),
        .rst  (rst),
        .din  ({comp_in, edge_in}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign e1 = '{rise: rise[0], fall: fall[0]};
    assign e2 = '{rise: rise[1], fall: fall[1]};

    chrg_ctrl_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .hi          (hi),
        .lo_cfg      (lo_cfg),
        .lo_wr       (lo_wr),
        .lo_wr_flags (lo_wr_flags)
    );

    chrg_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .hi          (hi),
        .lo_cfg      (lo_cfg),
        .lo_wr       (lo_wr),
        .lo_wr_flags (lo_wr_flags),
        .e1          (e1),
        .e2          (e2),
        .comp_lvl    (lvl[2]),
        .flag_a      (flag_a),
        .flag_b      (flag_b),
        .adc_trig    (adc_trig)
    );

    chrg_drive u_drv (
        .clk       (clk),
        .rst       (rst),
        .hi        (hi),
        .flag_a    (flag_a),
        .flag_b    (flag_b),
        .cur_en    (cur_en),
        .pulse_out (pulse_out),
        .dis_out   (dis_out)
    );

    always_comb begin
        lo_live        = lo_cfg;
        lo_live.flag_a = flag_a;
        lo_live.flag_b = flag_b;
        rd_data        = rd_sel ? REG_W'(lo_live) : REG_W'(hi);
    end

    p_edges_blocked_r4: assert property (@(posedge clk) disable iff (rst)
        !hi.edge_en && !hi.pulse_en && !lo_wr && !flag_a |=> !flag_a);

endmodule

// File: tb/chrg_gate_ctrl_bench.sv
module chrg_gate_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        string      req;
        logic [11:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b1;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] edge_in = 2'b00;
    logic       comp_in = 1'b0;
    logic       cur_en, dis_out, pulse_out, adc_trig;

    item_t q[$];
    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chrg_gate_ctrl u_chrg_gate_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .edge_in(edge_in), .comp_in(comp_in),
        .cur_en(cur_en), .dis_out(dis_out), .pulse_out(pulse_out), .adc_trig(adc_trig)
    );

    // expected vector: {adc_trig, dis_out, pulse_out, cur_en, rd_data}
    function automatic logic [11:0] ev(logic t, logic d, logic p, logic c, logic [7:0] r);
        return {t, d, p, c, r};
    endfunction

    task automatic push(string req, logic [11:0] exp);
        item_t it;
        it.req = req;
        it.exp = exp;
        q.push_back(it);
    endtask

    task automatic wr(logic sel, logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_in(logic [1:0] v);
        @(negedge clk);
        edge_in = v;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic set_comp(logic v);
        @(negedge clk);
        comp_in = v;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [11:0] got;
            it  = q.pop_front();
            got = {adc_trig, dis_out, pulse_out, cur_en, rd_data};
            vectors++;
            if (got !== it.exp) begin
                fails++;
                $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        push("R1 reset low reg", ev(0, 0, 0, 0, 8'h00));
        idle(1);
        rd_sel = 1'b0;
        push("R1 reset high reg", ev(0, 0, 0, 0, 8'h00));
        idle(1);
        rd_sel = 1'b1;

        // A: in1 rising, B: in2 falling; run still off
        wr(1'b1, 8'hB4);
        push("R10 config write while idle", ev(0, 0, 0, 0, 8'hB4));
        wr(1'b0, 8'h0F);
        push("R7 high write no trigger", ev(0, 0, 0, 0, 8'hB4));

        set_in(2'b01);
        push("R2 R5 R6 in1 rise sets A", ev(0, 0, 1, 1, 8'hB5));
        set_in(2'b11);
        push("R3 in2 rise ignored by falling B", ev(0, 0, 1, 1, 8'hB5));
        set_in(2'b01);
        push("R3 R7 in2 fall sets B closes window", ev(1, 0, 0, 0, 8'hB7));
        idle(1);
        push("R7 trigger single cycle", ev(0, 0, 0, 0, 8'hB7));

        wr(1'b1, 8'hB4);
        push("R3 R7 software clear evaluates", ev(1, 0, 0, 0, 8'hB4));
        set_in(2'b00);
        push("R3 in1 fall ignored by rising A", ev(0, 0, 0, 0, 8'hB4));

        wr(1'b0, 8'h0D);
        set_in(2'b01);
        push("R4 rise blocked when edge enable clear", ev(0, 0, 0, 0, 8'hB4));
        wr(1'b0, 8'h0F);
        idle(3);
        push("R4 no spurious edge on re-enable", ev(0, 0, 0, 0, 8'hB4));
        set_in(2'b00);
        set_in(2'b01);
        push("R4 edges resume", ev(0, 0, 1, 1, 8'hB5));

        wr(1'b0, 8'h1F);
        push("R9 discharge forces current off", ev(0, 1, 1, 0, 8'hB5));
        wr(1'b0, 8'h0F);
        push("R9 discharge clear restores current", ev(0, 0, 1, 1, 8'hB5));

        set_comp(1'b1);
        push("R8 comparator sets B", ev(1, 0, 0, 0, 8'hB7));
        set_comp(1'b0);
        wr(1'b1, 8'hB4);
        push("R3 R7 clear after comparator", ev(1, 0, 0, 0, 8'hB4));
        wr(1'b0, 8'h0B);
        set_comp(1'b1);
        push("R8 comparator ignored without pulse enable", ev(0, 0, 0, 0, 8'hB4));
        set_comp(1'b0);

        wr(1'b0, 8'h07);
        wr(1'b1, 8'hB4);
        push("R7 no trigger when disabled", ev(0, 0, 0, 0, 8'hB4));

        wr(1'b1, 8'h14);
        set_in(2'b00);
        set_in(2'b01);
        push("R2 select 01 unconnected", ev(0, 0, 0, 0, 8'h14));
        wr(1'b1, 8'h24);
        set_in(2'b11);
        push("R2 select 10 routes in2", ev(0, 0, 1, 1, 8'h25));

        wr(1'b0, 8'h1E);
        push("R10 run clear holds outputs low", ev(0, 0, 0, 0, 8'h25));
        wr(1'b1, 8'h24);
        push("R10 write loads flags while idle", ev(0, 0, 0, 0, 8'h24));
        set_in(2'b01);
        set_in(2'b11);
        push("R10 edges ignored while idle", ev(0, 0, 0, 0, 8'h24));
        set_comp(1'b1);
        push("R10 comparator ignored while idle", ev(0, 0, 0, 0, 8'h24));
        set_comp(1'b0);

        rd_sel = 1'b0;
        push("R11 high readback", ev(0, 0, 0, 0, 8'h1E));
        wr(1'b0, 8'hFF);
        push("R11 R9 reserved bits read zero", ev(0, 1, 0, 0, 8'h1F));

        idle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule